// File: doc/BRIEF.md
# Modulated Quadrature Direct Digital Synthesizer

This block generates a pair of sampled sinusoids, an in-phase and a quadrature channel exactly one quarter cycle apart, from a single 32-bit phase accumulator and one clock. Each accepted sample strobe advances the accumulator by a tuning step. The sampled phase is rounded to the nearest of 256 points per cycle. A stored quarter-wave magnitude table, read through address mirroring and sign inversion, turns that point into a signed sample for each channel.

Three modulation inputs enter at separate points. A signed frequency term is added to the tuning step before accumulation. A signed phase offset is added to the phase on its way to the table and is never stored back. An unsigned gain scales both table outputs. An optional pseudo-random addition to the fractional phase bits spreads the error of reading between table points. Samples leave with a valid flag at a fixed latency after the strobe.

Top module: `dds_quad`

## Requirements
- R1: While reset is low and after it is released, before any strobe, `i_out` and `q_out` are 0 and `out_valid` is low.
- R2: `out_valid` is high in the third cycle after a cycle in which `smp_en` is high, and low three cycles after a cycle in which it is low; the I and Q values shown with it belong to that strobe.
- R3: The 32-bit accumulator starts at 0 and, on each strobe, takes the sum of itself and the step, modulo 2^32. Each sample uses the accumulator value from before that strobe's update. Without a strobe it holds.
- R4: The table point is bits 31:24 of the sampled phase plus bit 23 (halves round up), modulo 256, so 255.5 or more yields point 0.
- R5: For point n, `i_out` before scaling equals 32767*sin(2*pi*n/256) rounded to the nearest integer: positive for n in 1..127, negative for n in 129..255, exactly 32767 at n=64 and -32767 at n=192.
- R6: `q_out` uses point (n+64) mod 256 of the same phase and the same strobe.
- R7: The accumulator step is `tune_word` plus the signed `fm_delta`, modulo 2^32.
- R8: `pm_offset` (signed) is added to the sampled phase of its own strobe only; it does not change the accumulator seen by later strobes.
- R9: Each output equals floor(s*g/65536), where s is the signed table sample and g is the unsigned `am_gain` applied with the same strobe.
- R10: With `dith_en` low the phase has no random term. With it high, a value in [0, 2^24) is added to the phase, so the point is either the undithered point n or n+1 (mod 256), and both occur over many strobes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| smp_en | input | 1 | Sample strobe; advances phase and launches one sample |
| tune_word | input | 32 | Unsigned phase step per strobe |
| fm_delta | input | 32 | Signed frequency-modulation term added to the step |
| pm_offset | input | 32 | Signed phase offset applied to the lookup only |
| am_gain | input | 16 | Unsigned fractional gain (value/65536) |
| dith_en | input | 1 | Enables pseudo-random fractional phase addition |
| i_out | output | 16 | Signed in-phase sample |
| q_out | output | 16 | Signed quadrature sample |
| out_valid | output | 1 | Marks I and Q as a new sample |

## Verification
The hardest things to reach from the ports are particular table points and the rounding boundaries, because the accumulator drifts with every strobe. The stimulus holds the step at zero and uses the phase offset to place the phase exactly: every one of the 256 points, fractions just under, at and above one half, and the 255.5 wrap. Offset strobes are then followed by zero-offset strobes to show the accumulator was not changed. Dither is checked against the two admissible points, and a fixed phase a quarter point above an entry must produce both of them.

// File: rtl/dds_quad_pkg.sv
package dds_quad_pkg;

   localparam real TWO_PI = 6.283185307179586;

   // Rounded magnitude of point addr in a quarter wave of depth points.
   function automatic int quarter_mag(int addr, int depth, int full);
      real ang;
      real v;
      ang = TWO_PI * real'(addr) / real'(4 * depth);
      v   = real'(full) * $sin(ang);
      return $rtoi(v + 0.5);
   endfunction

endpackage

// File: rtl/dds_lfsr.sv
module dds_lfsr #(
   parameter int W = 24
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         step,
   output logic [W-1:0] state
);

   logic fb;

   generate
      if (W == 24) begin : g_w24
         assign fb = state[23] ^ state[22] ^ state[21] ^ state[16];
      end else if (W == 16) begin : g_w16
         assign fb = state[15] ^ state[14] ^ state[12] ^ state[3];
      end else begin : g_bad
         $error("dds_lfsr: no tap set for this width");
         assign fb = 1'b0;
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n)    state <= W'(1);
      else if (step) state <= {state[W-2:0], fb};
   end

   // R10: a maximal sequence never reaches the all-zero lock state
   p_lfsr_live_r10: assert property (@(posedge clk) disable iff (!rst_n)
      step |=> state != '0);

endmodule

// File: rtl/dds_phase_front.sv
module dds_phase_front #(
   parameter int PHASE_W = 32,
   parameter int IDX_W   = 8,
   parameter int FRAC_W  = PHASE_W - IDX_W
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               smp_en,
   input  logic [PHASE_W-1:0] tune,
   input  logic [PHASE_W-1:0] fm,
   input  logic [PHASE_W-1:0] pm,
   input  logic               dith_en,
   input  logic [FRAC_W-1:0]  dith,
   output logic [IDX_W-1:0]   idx_i,
   output logic [IDX_W-1:0]   idx_q,
   output logic               v1
);

   localparam logic [IDX_W-1:0] QTR = IDX_W'(1) << (IDX_W - 2);

   logic [PHASE_W-1:0] acc;
   logic [PHASE_W-1:0] dith_ext;
   logic [PHASE_W-1:0] phase;
   logic [IDX_W-1:0]   near;

   assign dith_ext = dith_en ? {{IDX_W{1'b0}}, dith} : '0;
   assign phase    = acc + pm + dith_ext;
   assign near     = phase[PHASE_W-1 -: IDX_W] + IDX_W'(phase[FRAC_W-1]);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         acc   <= '0;
         idx_i <= '0;
         idx_q <= '0;
         v1    <= 1'b0;
      end else begin
         v1 <= smp_en;
         if (smp_en) begin
            acc   <= acc + tune + fm;
            idx_i <= near;
            idx_q <= near + QTR;
         end
      end
   end

   // R3: no strobe, no phase movement
   p_acc_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
      !smp_en |=> $stable(acc));

   // R8: a zero net step keeps the accumulator whatever the phase offset
   p_pm_no_store_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (smp_en && (tune + fm) == '0) |=> $stable(acc));

endmodule

// File: rtl/dds_sine_map.sv
module dds_sine_map #(
   parameter int IDX_W = 8,
   parameter int OUT_W = 16
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    en,
   input  logic [IDX_W-1:0]        idx,
   output logic signed [OUT_W-1:0] smp
);

   localparam int MAG_W  = OUT_W - 1;
   localparam int ADDR_W = IDX_W - 2;
   localparam int DEPTH  = 1 << ADDR_W;
   localparam int FULL   = (1 << MAG_W) - 1;
   localparam logic [IDX_W-1:0] QTR = IDX_W'(1) << ADDR_W;

   logic [MAG_W-1:0]  rom [DEPTH];
   logic [1:0]        quad;
   logic [ADDR_W-1:0] a;
   logic [ADDR_W-1:0] mirr;
   logic [MAG_W-1:0]  mag;

   for (genvar g = 0; g < DEPTH; g++) begin : g_rom
      localparam int V = dds_quad_pkg::quarter_mag(g, DEPTH, FULL);
      assign rom[g] = MAG_W'(V);
   end

   assign quad = idx[IDX_W-1 -: 2];
   assign a    = idx[ADDR_W-1:0];
   assign mirr = ~a + ADDR_W'(1);

   always_comb begin
      if (quad[0]) mag = (a == '0) ? MAG_W'(FULL) : rom[mirr];
      else         mag = rom[a];
   end

   always_ff @(posedge clk) begin
      if (!rst_n)  smp <= '0;
      else if (en) smp <= quad[1] ? -$signed({1'b0, mag}) : $signed({1'b0, mag});
   end

   // R5: first half cycle is never negative, second half never positive
   p_upper_half_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (en && !idx[IDX_W-1]) |=> smp >= 0);
   p_lower_half_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (en && idx[IDX_W-1]) |=> smp <= 0);
   // R5: the quarter point reaches full scale through the mirrored path
   p_peak_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (en && idx == QTR) |=> smp == FULL);

endmodule

// File: rtl/dds_am_scale.sv
module dds_am_scale #(
   parameter int OUT_W = 16,
   parameter int AM_W  = 16
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    en,
   input  logic signed [OUT_W-1:0] smp,
   input  logic [AM_W-1:0]         gain,
   output logic signed [OUT_W-1:0] y
);

   localparam int PROD_W = OUT_W + AM_W + 1;

   logic signed [PROD_W-1:0] prod;

   assign prod = PROD_W'(smp) * PROD_W'($signed({1'b0, gain}));

   always_ff @(posedge clk) begin
      if (!rst_n)  y <= '0;
      else if (en) y <= prod[AM_W +: OUT_W];
   end

   // R9: a gain below one never grows the magnitude or flips the sign
   p_am_shrink_r9: assert property (@(posedge clk) disable iff (!rst_n)
      en |=> ($past(smp) >= 0) ? (y >= 0 && y <= $past(smp))
                               : (y <= 0 && y >= $past(smp)));

endmodule

// File: rtl/dds_quad.sv
module dds_quad #(
   parameter int PHASE_W    = 32,
   parameter int IDX_W      = 8,
   parameter int OUT_W      = 16,
   parameter int AM_W       = 16,
   parameter bit USE_DITHER = 1'b1
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    smp_en,
   input  logic [PHASE_W-1:0]      tune_word,
   input  logic [PHASE_W-1:0]      fm_delta,
   input  logic [PHASE_W-1:0]      pm_offset,
   input  logic [AM_W-1:0]         am_gain,
   input  logic                    dith_en,
   output logic signed [OUT_W-1:0] i_out,
   output logic signed [OUT_W-1:0] q_out,
   output logic                    out_valid
);

   localparam int FRAC_W = PHASE_W - IDX_W;
   localparam int N_CH   = 2;

   if (IDX_W < 3)            $error("dds_quad: IDX_W too small");
   if (OUT_W < 4)            $error("dds_quad: OUT_W too small");
   if (PHASE_W <= IDX_W + 1) $error("dds_quad: no fractional phase bits");

   logic [FRAC_W-1:0]       dith;
   logic [IDX_W-1:0]        idx_ch [N_CH];
   logic signed [OUT_W-1:0] smp_ch [N_CH];
   logic signed [OUT_W-1:0] out_ch [N_CH];
   logic                    v1, v2;
   logic [AM_W-1:0]         am_p1, am_p2;

   generate
      if (USE_DITHER) begin : g_dither
         dds_lfsr #(.W(FRAC_W)) u_lfsr (
            .clk   (clk),
            .rst_n (rst_n),
            .step  (smp_en),
            .state (dith)
         );
      end else begin : g_no_dither
         assign dith = '0;
      end
   endgenerate

   dds_phase_front #(.PHASE_W(PHASE_W), .IDX_W(IDX_W), .FRAC_W(FRAC_W)) u_front (
      .clk     (clk),
      .rst_n   (rst_n),
      .smp_en  (smp_en),
      .tune    (tune_word),
      .fm      (fm_delta),
      .pm      (pm_offset),
      .dith_en (dith_en),
      .dith    (dith),
      .idx_i   (idx_ch[0]),
      .idx_q   (idx_ch[1]),
      .v1      (v1)
   );

   for (genvar c = 0; c < N_CH; c++) begin : g_ch
      dds_sine_map #(.IDX_W(IDX_W), .OUT_W(OUT_W)) u_map (
         .clk   (clk),
         .rst_n (rst_n),
         .en    (v1),
         .idx   (idx_ch[c]),
         .smp   (smp_ch[c])
      );
      dds_am_scale #(.OUT_W(OUT_W), .AM_W(AM_W)) u_am (
         .clk   (clk),
         .rst_n (rst_n),
         .en    (v2),
         .smp   (smp_ch[c]),
         .gain  (am_p2),
         .y     (out_ch[c])
      );
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         v2        <= 1'b0;
         out_valid <= 1'b0;
         am_p1     <= '0;
         am_p2     <= '0;
      end else begin
         v2        <= v1;
         out_valid <= v2;
         if (smp_en) am_p1 <= am_gain;
         if (v1)     am_p2 <= am_p1;
      end
   end

   assign i_out = out_ch[0];
   assign q_out = out_ch[1];

   // R2: fixed three-cycle latency, no sample without a strobe
   p_latency_r2: assert property (@(posedge clk) disable iff (!rst_n)
      smp_en |-> ##3 out_valid);
   p_no_spurious_r2: assert property (@(posedge clk) disable iff (!rst_n)
      !smp_en |-> ##3 !out_valid);

endmodule

// File: tb/dds_quad_test.sv
`timescale 1ns/1ps
module dds_quad_test;

   logic               clk = 1'b0;
   logic               rst_n = 1'b0;
   logic               smp_en = 1'b0;
   logic [31:0]        tune_word = '0;
   logic [31:0]        fm_delta = '0;
   logic [31:0]        pm_offset = '0;
   logic [15:0]        am_gain = '0;
   logic               dith_en = 1'b0;
   logic signed [15:0] i_out, q_out;
   logic               out_valid;

   int checks = 0;
   int errors = 0;
   int dith_lo = 0;
   int dith_hi = 0;

   logic [31:0] m_acc = '0;
   bit    pv [3];
   bit    pd [3];
   int    pi [3], pq [3], pi2 [3], pq2 [3];
   string pt [3];

   always #5 clk = ~clk;

   dds_quad uut (
      .clk(clk), .rst_n(rst_n), .smp_en(smp_en), .tune_word(tune_word),
      .fm_delta(fm_delta), .pm_offset(pm_offset), .am_gain(am_gain),
      .dith_en(dith_en), .i_out(i_out), .q_out(q_out), .out_valid(out_valid)
   );

   function automatic int sine_ref(int n);
      real v;
      v = 32767.0 * $sin(6.283185307179586 * real'(n) / 256.0);
      return (v >= 0.0) ? $rtoi(v + 0.5) : -$rtoi(-v + 0.5);
   endfunction

   function automatic int am_ref(int s, int g);
      longint p;
      p = longint'(s) * longint'(g);
      return int'(p >>> 16);
   endfunction

   function automatic int round_idx(logic [31:0] p);
      return (int'(p[31:24]) + int'(p[23])) & 255;
   endfunction

   task automatic chk(bit ok, string tag, int act, int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual %0d expected %0d", tag, act, exp);
      end
   endtask

   // One clock: drive at the falling edge, compare after the next rising edge.
   task automatic tick(bit en, logic [31:0] tw, logic [31:0] fm, logic [31:0] pm,
                       logic [15:0] am, bit dth, string tag);
      int r;
      smp_en = en; tune_word = tw; fm_delta = fm; pm_offset = pm;
      am_gain = am; dith_en = dth;
      for (int k = 2; k > 0; k--) begin
         pv[k] = pv[k-1]; pd[k] = pd[k-1]; pi[k] = pi[k-1]; pq[k] = pq[k-1];
         pi2[k] = pi2[k-1]; pq2[k] = pq2[k-1]; pt[k] = pt[k-1];
      end
      pv[0] = en; pd[0] = dth; pt[0] = tag;
      if (en) begin
         r = round_idx(m_acc + pm);
         pi[0]  = am_ref(sine_ref(r), int'(am));
         pq[0]  = am_ref(sine_ref((r + 64) & 255), int'(am));
         pi2[0] = am_ref(sine_ref((r + 1) & 255), int'(am));
         pq2[0] = am_ref(sine_ref((r + 65) & 255), int'(am));
         m_acc  = m_acc + tw + fm;
      end
      @(posedge clk);
      @(negedge clk);
      chk(out_valid == pv[2], "R2 valid", int'(out_valid), int'(pv[2]));
      if (pv[2] && out_valid) begin
         if (pd[2]) begin
            if (int'(i_out) == pi[2] && int'(q_out) == pq[2]) dith_lo++;
            else if (int'(i_out) == pi2[2] && int'(q_out) == pq2[2]) dith_hi++;
            chk((int'(i_out) == pi[2] && int'(q_out) == pq[2]) ||
                (int'(i_out) == pi2[2] && int'(q_out) == pq2[2]),
                {pt[2], " dithered I"}, int'(i_out), pi[2]);
         end else begin
            chk(int'(i_out) == pi[2], {pt[2], " I"}, int'(i_out), pi[2]);
            chk(int'(q_out) == pq[2], {pt[2], " Q R6"}, int'(q_out), pq[2]);
         end
      end
   endtask

   task automatic flush();
      for (int k = 0; k < 3; k++) tick(1'b0, '0, '0, '0, '0, 1'b0, "R2 idle");
   endtask

   initial begin
      #2_000_000;
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      void'($urandom(32'd4711));
      for (int k = 0; k < 3; k++) pv[k] = 1'b0;
      repeat (4) @(negedge clk);
      // R1: reset state, held and just after release
      chk(i_out == 0 && q_out == 0, "R1 reset data", int'(i_out), 0);
      chk(out_valid == 1'b0, "R1 reset valid", int'(out_valid), 0);
      rst_n = 1'b1;
      @(negedge clk);
      chk(i_out == 0 && q_out == 0 && !out_valid, "R1 after release", int'(i_out), 0);

      // R5 / R6: every table point placed by the phase offset, full gain
      for (int n = 0; n < 256; n++)
         tick(1'b1, '0, '0, 32'(n) << 24, 16'hFFFF, 1'b0, "R5 sweep");
      // R5 exact peaks at unity-minus-one gain are in the sweep; also half gain
      tick(1'b1, '0, '0, 32'h4000_0000, 16'h8000, 1'b0, "R5 peak");
      tick(1'b1, '0, '0, 32'hC000_0000, 16'h8000, 1'b0, "R5 trough");
      flush();

      // R4: rounding around one half, and the wrap from the last point
      tick(1'b1, '0, '0, 32'h0C66_6666, 16'hFFFF, 1'b0, "R4 12.4");
      tick(1'b1, '0, '0, 32'h0C99_9999, 16'hFFFF, 1'b0, "R4 12.6");
      tick(1'b1, '0, '0, 32'h0C7F_FFFF, 16'hFFFF, 1'b0, "R4 below half");
      tick(1'b1, '0, '0, 32'h0C80_0000, 16'hFFFF, 1'b0, "R4 exact half");
      tick(1'b1, '0, '0, 32'hFF80_0000, 16'hFFFF, 1'b0, "R4 wrap 255.5");
      tick(1'b1, '0, '0, 32'hFF7F_FFFF, 16'hFFFF, 1'b0, "R4 255 stays");
      flush();

      // R3: stepping, gaps that must hold the phase, and binary rollover
      for (int k = 0; k < 40; k++)
         tick(k % 3 != 2, 32'h0710_0000, '0, '0, 16'hFFFF, 1'b0, "R3 step");
      for (int k = 0; k < 12; k++)
         tick(1'b1, 32'hE000_0000, '0, '0, 16'hFFFF, 1'b0, "R3 rollover");
      flush();

      // R7: negative and positive frequency terms
      for (int k = 0; k < 20; k++)
         tick(1'b1, 32'h0300_0000, -32'sh0480_0000, '0, 16'hFFFF, 1'b0, "R7 fm neg");
      for (int k = 0; k < 20; k++)
         tick(1'b1, 32'h0100_0000, 32'h0234_5678, '0, 16'hFFFF, 1'b0, "R7 fm pos");

      // R8: offsets on some strobes, none on the next ones
      for (int k = 0; k < 10; k++)
         tick(1'b1, 32'h0100_0000, '0, 32'h5A00_0000, 16'hFFFF, 1'b0, "R8 with pm");
      for (int k = 0; k < 10; k++)
         tick(1'b1, 32'h0100_0000, '0, '0, 16'hFFFF, 1'b0, "R8 after pm");
      flush();

      // R9: gain corners
      tick(1'b1, '0, '0, 32'h2000_0000, 16'h0000, 1'b0, "R9 zero gain");
      tick(1'b1, '0, '0, 32'hA000_0000, 16'h0001, 1'b0, "R9 tiny gain neg");
      tick(1'b1, '0, '0, 32'h2000_0000, 16'h0001, 1'b0, "R9 tiny gain pos");
      tick(1'b1, '0, '0, 32'hE300_0000, 16'h8000, 1'b0, "R9 half gain");
      for (int k = 0; k < 200; k++)
         tick(1'b1, $urandom, '0, $urandom, 16'($urandom), 1'b0, "R9 random gain");
      flush();

      // R3 R7 R8 R9 together under random strobes
      for (int k = 0; k < 3000; k++)
         tick(($urandom % 4) != 0, $urandom, $urandom, $urandom,
              16'($urandom), 1'b0, "R7 random mix");
      flush();

      // R10: dithered strobes land on one of two neighbouring points
      for (int k = 0; k < 1500; k++)
         tick(($urandom % 4) != 0, $urandom, $urandom, $urandom,
              16'($urandom), 1'b1, "R10 random");
      flush();
      dith_lo = 0; dith_hi = 0;
      for (int k = 0; k < 300; k++)
         tick(1'b1, '0, '0, 32'h2840_0000, 16'hFFFF, 1'b1, "R10 fixed phase");
      flush();
      chk(dith_lo > 0, "R10 lower point seen", dith_lo, 1);
      chk(dith_hi > 0, "R10 upper point seen", dith_hi, 1);
      // R10: dither off afterwards leaves the exact point
      tick(1'b1, '0, '0, 32'h2840_0000, 16'hFFFF, 1'b0, "R10 off again");
      flush();

      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule